// File: doc/BRIEF.md
# Serial Flash Bulk-Erase Command Controller

This block is the instruction-decoding side of a serial flash device, limited to three commands: set the write-enable latch, read the status byte, and erase the whole array. A host drives a chip select, a serial clock and a serial data line. While chip select is low, the block collects data bits on rising serial-clock edges, most significant bit first. It treats the first complete byte of each selection as the instruction.

Whole-array erase is guarded in several ways. The write-enable latch must already be set. Both block-protect bits must be clear. The selection must end exactly after the eighth bit of the instruction byte. When the erase is committed, the block pulses an erase request to the memory array and runs a self-timed busy period, modelled by a down-counter in system clock cycles. The status byte can be read at any time, including during that period, and shows the busy flag live. The write-enable latch drops by itself a fixed number of cycles before the busy period ends. The protect bits are written through a separate load port.

All pins are sampled on a fast system clock. The serial clock must run several times slower than that clock.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset the status byte reads 00h, `so` is 0, `erase_busy` is 0 and no erase request has been issued.
- R2: Instruction 06h sets the write-enable latch (status bit 1) when the block is not busy.
- R3: Instruction 05h shifts out the status byte MSB first on `so`. The byte is laid out as bits 7:4 zero, bits 3:2 protect bits, bit 1 write-enable latch, bit 0 busy. Bit 7 is valid after the eighth rising SCK edge, and the next bit follows each later rising edge. The byte repeats while chip select stays low. `so` is 0 whenever chip select is high.
- R4: Instruction C7h commits only when chip select rises with no SCK rising edge after the eighth instruction bit. A selection that carries extra bits, or that ends before the byte completes, erases nothing.
- R5: Instruction C7h erases nothing unless the write-enable latch is set.
- R6: `bp_load` writes `bp_value` into the protect bits. Instruction C7h erases nothing while either protect bit is 1.
- R7: On commit, `erase_req` is high for one cycle. `erase_busy` (status bit 0) rises in that same cycle and stays high for exactly ERASE_CYCLES cycles.
- R8: During an erase the write-enable latch clears when WEL_CLEAR_LEFT busy cycles remain. It is therefore 0 before the busy flag falls, and it never reads 1 while the busy flag reads 0 after a commit.
- R9: While busy, every instruction except 05h is ignored. Instruction 06h does not set the latch and C7h issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in, sampled on SCK rising edges |
| so | output | 1 | Serial data out for the status read |
| bp_load | input | 1 | Load strobe for the protect bits |
| bp_value | input | 2 | New protect-bit value |
| erase_req | output | 1 | One-cycle erase request to the memory array |
| erase_busy | output | 1 | High while the self-timed erase runs |

## Verification
The checker assumes that every SCK level and every chip-select level is held for at least two system clocks. It also assumes that `si` is stable around each SCK rising edge, so each serial edge is seen exactly once. The bench meets this by changing pins only on falling system-clock edges and holding each SCK phase for three clocks. It sets `si` before raising SCK, and it keeps chip select high for four clocks between selections. Protect-bit loads are issued only between selections, so a committed erase always reflects the protect value seen at decode.

// File: rtl/flash_ctl_pkg.sv
// Shared opcodes and the status byte layout for the erase controller.
package flash_ctl_pkg;

    localparam logic [7:0] OP_SET_WEL  = 8'h06;
    localparam logic [7:0] OP_RD_STAT  = 8'h05;
    localparam logic [7:0] OP_CHIP_ERS = 8'hC7;

    // Status byte: bit0 busy, bit1 write-enable latch, bits 3:2 protect.
    typedef struct packed {
        logic [3:0] zero;
        logic [1:0] prot;
        logic       wel;
        logic       busy;
    } stat_t;

endpackage

// File: rtl/flash_spi_front.sv
// Serial front end. Registers the pins on clk, detects SCK rising edges
// and chip-select rising edges, and assembles the first byte of each
// selection as the opcode.
// Assumes SCK and chip-select levels last at least two clk cycles.
module flash_spi_front #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            si,
    output logic            cs_sync,
    output logic            cs_rise,
    output logic            sck_rise,
    output logic            op_valid,
    output logic [BITS-1:0] op_byte,
    output logic            on_boundary
);
    localparam int CW = $clog2(BITS);

    logic            cs_s, sck_s, si_s, cs_q, sck_q;
    logic [BITS-2:0] shreg;
    logic [CW-1:0]   bit_cnt;
    logic            op_seen;
    logic            byte_end;

    // Sample the pins and keep their previous values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_s  <= 1'b1;
            sck_s <= 1'b0;
            si_s  <= 1'b0;
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_s  <= cs_n;
            sck_s <= sck;
            si_s  <= si;
            cs_q  <= cs_s;
            sck_q <= sck_s;
        end
    end

    assign cs_sync     = cs_s;
    assign cs_rise     = cs_s & ~cs_q;
    assign sck_rise    = sck_s & ~sck_q & ~cs_s;
    assign byte_end    = sck_rise && (bit_cnt == CW'(BITS - 1));
    assign op_valid    = byte_end & ~op_seen;
    assign op_byte     = {shreg, si_s};
    assign on_boundary = (bit_cnt == '0);

    // Shift data bits and count them; a deselect clears the selection state.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            shreg   <= '0;
            bit_cnt <= '0;
            op_seen <= 1'b0;
        end else if (sck_rise) begin
            shreg   <= {shreg[BITS-3:0], si_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_end) op_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/flash_erase_timer.sv
// Self-timed erase period as a down-counter.
// busy is high for CYCLES cycles after start.
// wel_clr pulses once, when WEL_LEFT cycles of the period remain.
// Assumes 1 <= WEL_LEFT < CYCLES.
module flash_erase_timer #(
    parameter int CYCLES   = 64,
    parameter int WEL_LEFT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic wel_clr
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (start)          remain <= CW'(CYCLES);
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign busy    = (remain != '0);
    assign wel_clr = (remain == CW'(WEL_LEFT));

endmodule

// File: rtl/flash_status_tx.sv
// Status serializer. After a load it presents the live status MSB first
// and steps one bit per SCK rising edge, wrapping so the byte repeats.
// Drives 0 when no status read is active.
module flash_status_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_sync,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] status,
    output logic         so
);
    localparam int IW = $clog2(W);

    logic          active;
    logic [IW-1:0] idx;

    // Track the read window and the bit index within the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_sync) begin
            active <= 1'b0;
            idx    <= IW'(W - 1);
        end else if (load) begin
            active <= 1'b1;
            idx    <= IW'(W - 1);
        end else if (shift && active) begin
            idx    <= (idx == '0) ? IW'(W - 1) : idx - 1'b1;
        end
    end

    assign so = active & status[idx];

endmodule

// File: rtl/flash_erase_ctl.sv
// Top level of the serial flash erase controller. Decodes the write-enable,
// status-read and whole-array erase opcodes and owns the latch and the
// protect bits. It commits an erase only on a byte-aligned deselect.
// Assumes a serial clock several times slower than clk.
module flash_erase_ctl #(
    parameter int ERASE_CYCLES   = 64,
    parameter int WEL_CLEAR_LEFT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    output logic       so,
    input  logic       bp_load,
    input  logic [1:0] bp_value,
    output logic       erase_req,
    output logic       erase_busy
);
    import flash_ctl_pkg::*;

    localparam int OPW = 8;

    logic           cs_sync, cs_rise, sck_rise, op_valid, on_boundary;
    logic [OPW-1:0] op_byte;
    logic           wip, wel_clr;
    logic           wel_q, pend_q, erase_go;
    logic [1:0]     bp_q;
    logic           hit_wel, hit_rd, hit_ers;
    stat_t          stat;

    flash_spi_front #(.BITS(OPW)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sck         (sck),
        .si          (si),
        .cs_sync     (cs_sync),
        .cs_rise     (cs_rise),
        .sck_rise    (sck_rise),
        .op_valid    (op_valid),
        .op_byte     (op_byte),
        .on_boundary (on_boundary)
    );

    flash_erase_timer #(
        .CYCLES   (ERASE_CYCLES),
        .WEL_LEFT (WEL_CLEAR_LEFT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (erase_go),
        .busy    (wip),
        .wel_clr (wel_clr)
    );

    // Opcode hits, each gated by the busy and guard conditions.
    always_comb begin
        hit_wel = op_valid && (op_byte == OP_SET_WEL) && !wip;
        hit_rd  = op_valid && (op_byte == OP_RD_STAT);
        hit_ers = op_valid && (op_byte == OP_CHIP_ERS) && !wip
                  && wel_q && (bp_q == 2'b00);
    end

    // Write-enable latch: set by its opcode, cleared by the erase timer.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel_q <= 1'b0;
        else if (wel_clr) wel_q <= 1'b0;
        else if (hit_wel) wel_q <= 1'b1;
    end

    // Protect bits written from the load port.
    always_ff @(posedge clk) begin
        if (!rst_n)       bp_q <= 2'b00;
        else if (bp_load) bp_q <= bp_value;
    end

    // Erase is pending after its opcode; any further bit or deselect drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (cs_rise)  pend_q <= 1'b0;
        else if (hit_ers)  pend_q <= 1'b1;
        else if (sck_rise) pend_q <= 1'b0;
    end

    assign erase_go = cs_rise && pend_q && on_boundary;

    // Registered one-cycle request to the array, aligned with busy rising.
    always_ff @(posedge clk) begin
        if (!rst_n) erase_req <= 1'b0;
        else        erase_req <= erase_go;
    end

    always_comb begin
        stat      = '0;
        stat.prot = bp_q;
        stat.wel  = wel_q;
        stat.busy = wip;
    end

    flash_status_tx #(.W(OPW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_sync (cs_sync),
        .load    (hit_rd),
        .shift   (sck_rise),
        .status  (stat),
        .so      (so)
    );

    assign erase_busy = wip;

endmodule

// File: rtl/flash_erase_ctl_chk.sv
// Checker for the erase controller, bound to the top module.
module flash_erase_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_sync,
    input logic so,
    input logic wel_q,
    input logic erase_req,
    input logic erase_busy
);
    // R3
    so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_sync |=> (so == 1'b0));
    // R5
    req_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(wel_q));
    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_busy) |-> erase_req);
    // R7
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> (!erase_req && erase_busy));
    // R8
    wel_before_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_busy) |-> !wel_q);
    // R9
    wel_set_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> !$past(erase_busy));
endmodule

bind flash_erase_ctl flash_erase_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_sync    (cs_sync),
    .so         (so),
    .wel_q      (wel_q),
    .erase_req  (erase_req),
    .erase_busy (erase_busy)
);

// File: tb/flash_erase_ctl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module flash_erase_ctl_bench;
    localparam int CYC  = 300;
    localparam int LEFT = 100;
    localparam int H    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic bp_load = 1'b0;
    logic [1:0] bp_value = 2'b00;
    logic so, erase_req, erase_busy;

    int checks = 0, errors = 0;
    int req_cnt = 0, busy_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_erase_ctl #(.ERASE_CYCLES(CYC), .WEL_CLEAR_LEFT(LEFT)) u_flash_erase_ctl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
        .bp_load(bp_load), .bp_value(bp_value),
        .erase_req(erase_req), .erase_busy(erase_busy)
    );

    always @(negedge clk) begin
        if (rst_n && erase_req)  req_cnt++;
        if (rst_n && erase_busy) busy_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sel;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic desel;
        @(negedge clk) cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk) si = b;
        repeat (H - 1) @(negedge clk);
        sck = 1'b1;
        repeat (H) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
    endtask

    task automatic get_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            repeat (H) @(negedge clk);
            v[i] = so;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cmd(input logic [7:0] op);
        sel; put_byte(op); desel;
    endtask

    task automatic rd_stat(output logic [7:0] v);
        sel; put_byte(8'h05); get_byte(v); desel;
    endtask

    task automatic load_bp(input logic [1:0] v);
        @(negedge clk) begin bp_load = 1'b1; bp_value = v; end
        @(negedge clk) bp_load = 1'b0;
    endtask

    task automatic wait_idle;
        while (erase_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 so", so, 0);
        chk("R1 busy", erase_busy, 0);
        rd_stat(v);
        chk("R1 status", v, 8'h00);
        chk("R1 req count", req_cnt, 0);
    endtask

    task automatic t_wren_and_repeat;
        logic [7:0] a, b;
        cmd(8'h06);
        sel; put_byte(8'h05); get_byte(a); get_byte(b); desel;
        chk("R2 latch set", a, 8'h02);
        chk("R3 status repeats", b, 8'h02);
        chk("R3 so idle", so, 0);
    endtask

    task automatic t_protect;
        logic [7:0] v;
        int r0 = req_cnt;
        load_bp(2'b01);
        cmd(8'hC7);
        rd_stat(v);
        chk("R6 bp=01 status", v, 8'h06);
        load_bp(2'b10);
        cmd(8'hC7);
        rd_stat(v);
        chk("R6 bp=10 status", v, 8'h0A);
        chk("R6 no request", req_cnt, r0);
        chk("R6 not busy", erase_busy, 0);
        load_bp(2'b00);
    endtask

    task automatic t_misaligned;
        logic [7:0] v;
        int r0 = req_cnt;
        sel; put_byte(8'hC7); put_bit(1'b0); desel;
        chk("R4 extra bit no request", req_cnt, r0);
        sel; put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); desel;
        chk("R4 short byte no request", req_cnt, r0);
        sel; put_byte(8'hC7); put_byte(8'h00); desel;
        chk("R4 two bytes no request", req_cnt, r0);
        rd_stat(v);
        chk("R4 latch kept", v, 8'h02);
    endtask

    task automatic t_no_wel;
        logic [7:0] v;
        int r0;
        cmd(8'hC7);
        cmd(8'hC7);
        rd_stat(v);
        // latch still 1 from earlier; clear it via a full erase first
        r0 = req_cnt;
        chk("R5 erase with latch", r0 > 0, 1);
        wait_idle;
        r0 = req_cnt;
        cmd(8'hC7);
        chk("R5 no latch no request", req_cnt, r0);
        chk("R5 no latch not busy", erase_busy, 0);
    endtask

    task automatic t_erase_live;
        logic [7:0] v;
        bit saw3 = 0, saw1 = 0, bad = 0;
        int r0 = req_cnt, b0;
        cmd(8'h06);
        b0 = busy_cnt;
        cmd(8'hC7);
        chk("R7 one request", req_cnt, r0 + 1);
        chk("R7 busy after commit", erase_busy, 1);
        sel; put_byte(8'h05);
        for (int k = 0; k < 20; k++) begin
            get_byte(v);
            if (v == 8'h03) saw3 = 1;
            if (v == 8'h01) saw1 = 1;
            if (v[1] && !v[0]) bad = 1;
            if (!erase_busy) break;
        end
        desel;
        wait_idle;
        chk("R3 live status busy+latch", saw3, 1);
        chk("R8 latch cleared while busy", saw1, 1);
        chk("R8 latch never after busy", bad, 0);
        chk("R7 busy length", busy_cnt - b0, CYC);
        rd_stat(v);
        chk("R8 final status", v, 8'h00);
    endtask

    task automatic t_busy_ignores;
        logic [7:0] v;
        int r0;
        cmd(8'h06);
        cmd(8'hC7);
        r0 = req_cnt;
        repeat (210) @(negedge clk);
        cmd(8'h06);
        cmd(8'hC7);
        wait_idle;
        chk("R9 no second request", req_cnt, r0);
        rd_stat(v);
        chk("R9 latch not set while busy", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_wren_and_repeat;
        t_protect;
        t_misaligned;
        t_no_wel;
        t_erase_live;
        t_busy_ignores;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule